// File: doc/BRIEF.md
# Sizable Base Address Register

This block is the device-side logic for a single 32-bit base address register in a type-0 configuration header. Parameters fix the space it claims: memory or I/O, a power-of-two window size, and, for memory, the type code and the prefetchable flag. Those attribute bits sit in the low nibble. They are hardwired, so every read shows them and no write can change them.

Base bits below the window size are tied to zero and drop whatever is written to them. Enumeration software finds the size by writing all ones and reading the value back. The lowest set bit above the attribute nibble is the window size. Software then writes back the original base, and the register decodes it normally.

A combinational hit output goes high when a valid probe address falls inside the programmed window. It does so only while the command-register enable for the block's own space is set. An I/O window decodes a 16-bit port space.

Top module: `bar_window`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the read data holds only the attribute bits and the base is zero.
- R2: For a memory window, read bit 0 is 0. Read bits 2:1 carry the type code: 00 for 32-bit, 01 for below 1 MB, 10 for 64-bit. Read bit 3 is the prefetchable flag. No write changes these bits.
- R3: For an I/O window, read bit 0 is 1 and read bit 1 is always 0, whatever is written.
- R4: Base bits below log2 of the window size always read zero. Writes to those bits have no effect.
- R5: A write of all ones reads back as the writable mask plus the attributes. Above the attribute bits, the lowest set bit of that value equals the window size. With the defaults (4 KiB memory, prefetchable) it reads 0xFFFFF008.
- R6: After the sizing write, writing the original base back restores both the read value and address decoding.
- R7: For an I/O window, read bits 31:16 are always zero. A probe address with any of bits 31:16 set never hits.
- R8: The hit output is 1 under three conditions together: the probe is valid, the space enable for the block's space is set, and probe bits from log2(size) upward equal the programmed base.
- R9: The hit output is 0 whenever the probe is not valid or the block's own space enable is clear. The other space's enable has no effect.
- R10: In a cycle with no write, the read data keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data for the register |
| rd_data | output | 32 | Register read value: base bits plus attribute bits |
| mem_en | input | 1 | Memory space enable from the command register |
| io_en | input | 1 | I/O space enable from the command register |
| probe_valid | input | 1 | Probe address is valid |
| probe_addr | input | 32 | Address to be decoded |
| hit | output | 1 | Probe falls inside the programmed window |

## Verification
The write path is tried with several data patterns: all ones, all zeros, data that sets only bits below the window, and mixed patterns. These separate correct masking from a register that stores too many or too few bits, and from writes that leak into the attribute nibble. Three configurations are tested: a prefetchable 4 KiB memory window, a 1 MiB below-1-MB memory window, and a 32-byte I/O window. Comparing them shows that the attribute codes and size masks follow the parameters. Hit probes are placed at the first and last byte of the window, just outside it on both sides, and above 64 KiB for I/O. The space enables are toggled, including setting only the wrong space's enable. These probes show the exact comparison boundary and the gating by the enables.

// File: rtl/bar_pkg.sv
package bar_pkg;

    // Space selector values as seen in read bit 0
    typedef enum logic {
        SPACE_MEM = 1'b0,
        SPACE_IO  = 1'b1
    } bar_space_e;

    // Memory type codes, read bits 2:1
    typedef enum logic [1:0] {
        MTYPE_32   = 2'b00,
        MTYPE_1M   = 2'b01,
        MTYPE_64   = 2'b10,
        MTYPE_RSVD = 2'b11
    } bar_mtype_e;

    localparam int BAR_W = 32;

    // Lowest set bit of a word, used when forming window sizes
    function automatic logic [BAR_W-1:0] low_one(input logic [BAR_W-1:0] v);
        return v & (~v + 1'b1);
    endfunction

endpackage

// File: rtl/bar_cfg_const.sv
module bar_cfg_const
    import bar_pkg::*;
#(
    parameter int IS_IO     = 0,
    parameter int SIZE_LOG2 = 12,
    parameter int MEM_TYPE  = 0,
    parameter int PREFETCH  = 1
) (
    output logic [BAR_W-1:0] attr_o,
    output logic [BAR_W-1:0] wmask_o,
    output logic [BAR_W-1:0] cmask_o
);

    localparam logic [BAR_W-1:0] BELOW = (BAR_W'(1) << SIZE_LOG2) - BAR_W'(1);
    localparam logic [BAR_W-1:0] PORT_LIMIT = 32'h0000_FFFF;

    // Compare mask covers every bit at or above the window size
    assign cmask_o = ~BELOW;

    generate
        if (IS_IO != 0) begin : g_io
            assign attr_o  = {{(BAR_W-1){1'b0}}, SPACE_IO};
            assign wmask_o = ~BELOW & PORT_LIMIT;
        end else begin : g_mem
            localparam bar_mtype_e MT = bar_mtype_e'(MEM_TYPE[1:0]);
            assign attr_o  = {{(BAR_W-4){1'b0}}, (PREFETCH != 0), MT, SPACE_MEM};
            assign wmask_o = ~BELOW;
        end
    endgenerate

endmodule

// File: rtl/bar_base_reg.sv
module bar_base_reg
    import bar_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BAR_W-1:0] wr_data,
    input  logic [BAR_W-1:0] wmask,
    output logic [BAR_W-1:0] base_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr_en) begin
            base_q <= wr_data & wmask;
        end
    end

endmodule

// File: rtl/bar_addr_match.sv
module bar_addr_match
    import bar_pkg::*;
(
    input  logic             space_en,
    input  logic             probe_valid,
    input  logic [BAR_W-1:0] probe_addr,
    input  logic [BAR_W-1:0] base,
    input  logic [BAR_W-1:0] cmask,
    output logic             hit
);

    logic [BAR_W-1:0] diff;

    always_comb begin
        diff = (probe_addr ^ base) & cmask;
        hit  = probe_valid && space_en && (diff == '0);
    end

endmodule

// File: rtl/bar_window.sv
module bar_window
    import bar_pkg::*;
#(
    parameter int IS_IO     = 0,
    parameter int SIZE_LOG2 = 12,
    parameter int MEM_TYPE  = 0,
    parameter int PREFETCH  = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        mem_en,
    input  logic        io_en,
    input  logic        probe_valid,
    input  logic [31:0] probe_addr,
    output logic        hit
);

    logic [BAR_W-1:0] attr;
    logic [BAR_W-1:0] wmask;
    logic [BAR_W-1:0] cmask;
    logic [BAR_W-1:0] base_q;
    logic             space_en;

    bar_cfg_const #(
        .IS_IO    (IS_IO),
        .SIZE_LOG2(SIZE_LOG2),
        .MEM_TYPE (MEM_TYPE),
        .PREFETCH (PREFETCH)
    ) u_cfg (
        .attr_o (attr),
        .wmask_o(wmask),
        .cmask_o(cmask)
    );

    bar_base_reg u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .wmask  (wmask),
        .base_q (base_q)
    );

    generate
        if (IS_IO != 0) begin : g_io_en
            assign space_en = io_en;
        end else begin : g_mem_en
            assign space_en = mem_en;
        end
    endgenerate

    bar_addr_match u_match (
        .space_en   (space_en),
        .probe_valid(probe_valid),
        .probe_addr (probe_addr),
        .base       (base_q),
        .cmask      (cmask),
        .hit        (hit)
    );

    assign rd_data = base_q | attr;

endmodule

// File: rtl/bar_window_chk.sv
module bar_window_chk #(
    parameter int IS_IO     = 0,
    parameter int SIZE_LOG2 = 12,
    parameter int MEM_TYPE  = 0,
    parameter int PREFETCH  = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        mem_en,
    input logic        io_en,
    input logic        probe_valid,
    input logic        hit
);

    localparam logic [31:0] EXP_ATTR = (IS_IO != 0) ? 32'h1 :
        ((PREFETCH != 0 ? 32'h8 : 32'h0) | (32'(MEM_TYPE & 3) << 1));
    localparam logic [31:0] KEEP = (IS_IO != 0) ?
        ((32'hFFFF_FFFF << SIZE_LOG2) & 32'h0000_FFFF) : (32'hFFFF_FFFF << SIZE_LOG2);

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> rd_data == EXP_ATTR);

    // R2
    attr_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3:0] == EXP_ATTR[3:0]);

    // R4
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~KEEP) == EXP_ATTR);

    // R5
    write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == (($past(wr_data) & KEEP) | EXP_ATTR));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

    // R9
    hit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (probe_valid && ((IS_IO != 0) ? io_en : mem_en)));

endmodule

bind bar_window bar_window_chk #(
    .IS_IO    (IS_IO),
    .SIZE_LOG2(SIZE_LOG2),
    .MEM_TYPE (MEM_TYPE),
    .PREFETCH (PREFETCH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .mem_en     (mem_en),
    .io_en      (io_en),
    .probe_valid(probe_valid),
    .hit        (hit)
);

// File: tb/bar_window_tb.sv
module bar_window_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_m = 1'b0, wr_i = 1'b0, wr_b = 1'b0;
    logic [31:0] wr_data = '0;
    logic        mem_en = 1'b0, io_en = 1'b0, probe_valid = 1'b0;
    logic [31:0] probe_addr = '0;
    logic [31:0] rd_m, rd_i, rd_b;
    logic        hit_m, hit_i, hit_b;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    bar_window u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_m), .wr_data(wr_data), .rd_data(rd_m),
        .mem_en(mem_en), .io_en(io_en), .probe_valid(probe_valid),
        .probe_addr(probe_addr), .hit(hit_m));

    bar_window #(.IS_IO(1), .SIZE_LOG2(5)) u_dut_io (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_i), .wr_data(wr_data), .rd_data(rd_i),
        .mem_en(mem_en), .io_en(io_en), .probe_valid(probe_valid),
        .probe_addr(probe_addr), .hit(hit_i));

    bar_window #(.SIZE_LOG2(20), .MEM_TYPE(1), .PREFETCH(0)) u_dut_b1m (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_b), .wr_data(wr_data), .rd_data(rd_b),
        .mem_en(mem_en), .io_en(io_en), .probe_valid(probe_valid),
        .probe_addr(probe_addr), .hit(hit_b));

    // {write data, expected read-back} for the default memory window
    localparam logic [63:0] VEC [6] = '{
        {32'hFFFF_FFFF, 32'hFFFF_F008},
        {32'h0000_0000, 32'h0000_0008},
        {32'h1234_5678, 32'h1234_5008},
        {32'h0000_0FFF, 32'h0000_0008},
        {32'hABCD_E123, 32'hABCD_E008},
        {32'h8000_1000, 32'h8000_1008}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int which, input logic [31:0] d);
        @(negedge clk);
        wr_data = d;
        wr_m = (which == 0);
        wr_i = (which == 1);
        wr_b = (which == 2);
        @(negedge clk);
        wr_m = 1'b0; wr_i = 1'b0; wr_b = 1'b0;
    endtask

    task automatic probe(input logic v, input logic [31:0] a);
        probe_valid = v;
        probe_addr = a;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values: attribute bits only
        chk("R1 mem reset", rd_m, 32'h0000_0008);
        chk("R1 io reset", rd_i, 32'h0000_0001);
        chk("R1 b1m reset", rd_b, 32'h0000_0002);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mem after release", rd_m, 32'h0000_0008);

        // R2 R4 R5 vector walk on the default memory window
        for (int i = 0; i < 6; i++) begin
            wr(0, VEC[i][63:32]);
            chk("R4 R2 mem vector", rd_m, VEC[i][31:0]);
        end

        // R10 no write: value holds over several cycles
        repeat (4) @(negedge clk);
        chk("R10 hold", rd_m, 32'h8000_1008);

        // R5 sizing write and lowest-bit size
        wr(0, 32'hFFFF_FFFF);
        chk("R5 mem sizing", rd_m, 32'hFFFF_F008);
        chk("R5 mem size", bar_pkg::low_one(rd_m & 32'hFFFF_FFF0), 32'h0000_1000);
        // R6 restore and decode
        wr(0, 32'h4000_0000);
        chk("R6 mem restore", rd_m, 32'h4000_0008);
        mem_en = 1'b1; io_en = 1'b0;
        probe(1'b1, 32'h4000_0000); chk("R8 first byte", 32'(hit_m), 32'd1);
        probe(1'b1, 32'h4000_0FFF); chk("R6 R8 last byte", 32'(hit_m), 32'd1);
        probe(1'b1, 32'h4000_1000); chk("R8 above window", 32'(hit_m), 32'd0);
        probe(1'b1, 32'h3FFF_FFFF); chk("R8 below window", 32'(hit_m), 32'd0);
        probe(1'b0, 32'h4000_0100); chk("R9 probe invalid", 32'(hit_m), 32'd0);
        mem_en = 1'b0; io_en = 1'b1;
        probe(1'b1, 32'h4000_0100); chk("R9 wrong space enable", 32'(hit_m), 32'd0);

        // R2 below-1MB type, not prefetchable
        wr(2, 32'hFFFF_FFFF);
        chk("R2 R5 b1m sizing", rd_b, 32'hFFF0_0002);
        chk("R5 b1m size", bar_pkg::low_one(rd_b & 32'hFFFF_FFF0), 32'h0010_0000);

        // R3 R7 I/O window
        wr(1, 32'hFFFF_FFFF);
        chk("R3 R7 io sizing", rd_i, 32'h0000_FFE1);
        chk("R5 io size", bar_pkg::low_one(rd_i & 32'h0000_FFFC), 32'h0000_0020);
        wr(1, 32'hFFFF_C042);
        chk("R3 R7 io write", rd_i, 32'h0000_C041);
        io_en = 1'b1; mem_en = 1'b0;
        probe(1'b1, 32'h0000_C05F); chk("R8 io hit", 32'(hit_i), 32'd1);
        probe(1'b1, 32'h0000_C060); chk("R8 io past end", 32'(hit_i), 32'd0);
        probe(1'b1, 32'h0001_C040); chk("R7 io upper bits", 32'(hit_i), 32'd0);
        io_en = 1'b0; mem_en = 1'b1;
        probe(1'b1, 32'h0000_C040); chk("R9 io disabled", 32'(hit_i), 32'd0);
        probe(1'b0, 32'h0);

        // R1 reset mid-run clears the base
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mem re-reset", rd_m, 32'h0000_0008);
        chk("R1 io re-reset", rd_i, 32'h0000_0001);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #4_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule